// File: doc/BRIEF.md
# Bridge Error Status and System-Error Aggregator

This block gathers error events for a PCI-to-PCI style bridge and holds a sticky status bit for each kind. Its inputs are single-cycle event pulses. On the upstream side these are a data parity error, an error returned on a cycle the bridge mastered, and a received master abort. On the downstream side they are a data parity error and a returned error on a mastered cycle. Three system-bus error sources complete the set. Enable bits from the command and bridge-control registers arrive as static inputs.

Errors fall into three classes, and each class has its own gate. Upstream errors count only when upstream parity response is enabled. Downstream errors count only when downstream parity response is enabled. Each system-bus source counts only when its own enable is set. The gated classes are ORed together, and a global system-error enable then controls two things: the registered one-cycle system-error pulse, and the status bit that logs it. The upstream parity-detected bit sets whatever the enables are.

Software reads status through a small register port and clears bits by writing ones. The active-low conversion of the system-error pulse is done outside the block.

Top module: `bridge_err_agg`

## Requirements
- R1: After synchronous reset, `serr_o` is 0 and both status words read 0x0000.
- R2: A `pri_data_perr` pulse sets status word 0, bit 0 (parity detected), whatever the state of every enable input.
- R3: A `pri_data_perr` or `pri_mst_err` pulse raises `serr_o` only when `cfg_pri_perr_en` is 1.
- R4: A `sec_data_perr` or `sec_mst_err` pulse raises `serr_o` only when `cfg_sec_perr_en` is 1.
- R5: A pulse on `sbus_err[i]` always sets status word 1, bit i. It raises `serr_o` only when `cfg_sbus_en[i]` is 1.
- R6: `serr_o` rises, and status word 0 bit 1 (system error signaled) sets, only when `cfg_serr_en` is 1 together with a qualifying class event.
- R7: A `pri_mabort` pulse sets status word 0, bit 2 (master abort received).
- R8: Writing to address 0 or address 1 clears each status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged.
- R9: When a status bit's set event and its write-one clear fall in the same cycle, the bit ends set.
- R10: `serr_o` is registered. It is 1 in the cycle after the qualifying event and falls back to 0 one cycle later if no new event arrives.
- R11: While `reg_rd` is 1, `reg_rdata` returns the addressed word combinationally, and addresses 2 and 3 read 0x0000. While `reg_rd` is 0, `reg_rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_data_perr | input | 1 | Data parity error detected on the upstream side |
| pri_mst_err | input | 1 | Error returned on an upstream cycle the bridge mastered |
| pri_mabort | input | 1 | Master-abort completion received upstream |
| sec_data_perr | input | 1 | Data parity error detected on the downstream side |
| sec_mst_err | input | 1 | Error returned on a downstream cycle the bridge mastered |
| sbus_err | input | 3 | System-bus error event pulses |
| cfg_pri_perr_en | input | 1 | Upstream parity-response enable |
| cfg_sec_perr_en | input | 1 | Downstream parity-response enable |
| cfg_sbus_en | input | 3 | Per-source system-bus error enables |
| cfg_serr_en | input | 1 | Global system-error enable |
| reg_addr | input | 2 | Status register address |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data |
| reg_wr | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata | input | 16 | Write data |
| serr_o | output | 1 | Registered active-high system-error pulse |

## Verification
A wrong gate on one class shows at `serr_o` one cycle after a single event pulse: the pulse either appears when it should not or is missing. A status bit that fails to stick, or that clears the wrong bit, shows on the next register read. The bench reads right after each stimulus and after each clear, so the fault is caught within two cycles. A reversed set-versus-clear priority is exposed by a read taken directly after the cycle in which the two collide.

// File: rtl/brerr_pkg.sv
package brerr_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;
    localparam int BR_N   = 3;
    localparam int SB_N   = 3;
    localparam int LOW_N  = (BR_N > SB_N) ? BR_N : SB_N;

    localparam logic [ADDR_W-1:0] ADDR_BRIDGE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SBUS   = 2'd1;

    localparam int BIT_DPE = 0;
    localparam int BIT_SSE = 1;
    localparam int BIT_RMA = 2;

    typedef struct packed {
        logic data_perr;
        logic mst_err;
    } side_ev_t;

    function automatic logic [REG_W-1:0] widen(input logic [LOW_N-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[LOW_N-1:0] = v;
        return r;
    endfunction
endpackage

// File: rtl/brerr_class.sv
module brerr_class #(
    parameter int N = 2
) (
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    output logic         hit
);
    assign hit = |(ev & en);
endmodule

// File: rtl/brerr_w1c.sv
module brerr_w1c #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/brerr_regif.sv
module brerr_regif
    import brerr_pkg::*;
(
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [BR_N-1:0]   br_q,
    input  logic [SB_N-1:0]   sb_q,
    output logic [REG_W-1:0]  rdata,
    output logic [BR_N-1:0]   br_clr,
    output logic [SB_N-1:0]   sb_clr
);
    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:LOW_N];

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_BRIDGE)
                rdata = widen(LOW_N'(br_q));
            else if (addr == ADDR_SBUS)
                rdata = widen(LOW_N'(sb_q));
        end
    end

    always_comb begin
        br_clr = '0;
        sb_clr = '0;
        if (wr && addr == ADDR_BRIDGE)
            br_clr = wdata[BR_N-1:0];
        if (wr && addr == ADDR_SBUS)
            sb_clr = wdata[SB_N-1:0];
    end
endmodule

// File: rtl/bridge_err_agg.sv
module bridge_err_agg
    import brerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pri_data_perr,
    input  logic              pri_mst_err,
    input  logic              pri_mabort,
    input  logic              sec_data_perr,
    input  logic              sec_mst_err,
    input  logic [SB_N-1:0]   sbus_err,
    input  logic              cfg_pri_perr_en,
    input  logic              cfg_sec_perr_en,
    input  logic [SB_N-1:0]   cfg_sbus_en,
    input  logic              cfg_serr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              serr_o
);
    side_ev_t pri_ev, sec_ev;
    assign pri_ev = '{data_perr: pri_data_perr, mst_err: pri_mst_err};
    assign sec_ev = '{data_perr: sec_data_perr, mst_err: sec_mst_err};

    logic pri_hit, sec_hit, sb_hit, serr_next;

    brerr_class #(.N(2)) u_pri (
        .ev (pri_ev),
        .en ({2{cfg_pri_perr_en}}),
        .hit(pri_hit)
    );
    brerr_class #(.N(2)) u_sec (
        .ev (sec_ev),
        .en ({2{cfg_sec_perr_en}}),
        .hit(sec_hit)
    );
    brerr_class #(.N(SB_N)) u_sbus (
        .ev (sbus_err),
        .en (cfg_sbus_en),
        .hit(sb_hit)
    );

    assign serr_next = cfg_serr_en & (pri_hit | sec_hit | sb_hit);

    always_ff @(posedge clk) begin
        if (rst)
            serr_o <= 1'b0;
        else
            serr_o <= serr_next;
    end

    logic [BR_N-1:0] br_set, br_clr, br_q;
    logic [SB_N-1:0] sb_clr, sb_q;

    always_comb begin
        br_set          = '0;
        br_set[BIT_DPE] = pri_data_perr;
        br_set[BIT_SSE] = serr_next;
        br_set[BIT_RMA] = pri_mabort;
    end

    brerr_w1c #(.N(BR_N)) u_br_st (
        .clk(clk), .rst(rst), .set(br_set), .clr(br_clr), .q(br_q)
    );
    brerr_w1c #(.N(SB_N)) u_sb_st (
        .clk(clk), .rst(rst), .set(sbus_err), .clr(sb_clr), .q(sb_q)
    );

    brerr_regif u_regif (
        .rd    (reg_rd),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .br_q  (br_q),
        .sb_q  (sb_q),
        .rdata (reg_rdata),
        .br_clr(br_clr),
        .sb_clr(sb_clr)
    );
endmodule

// File: rtl/brerr_checker.sv
module brerr_checker
    import brerr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pri_data_perr,
    input logic            pri_mst_err,
    input logic            pri_mabort,
    input logic [SB_N-1:0] sbus_err,
    input logic            cfg_pri_perr_en,
    input logic            cfg_serr_en,
    input logic            serr_o,
    input logic [BR_N-1:0] st_br,
    input logic [SB_N-1:0] st_sb
);
    AST_SERR_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (serr_o && !$past(rst)) |-> $past(cfg_serr_en)); // R6

    AST_SERR_LOGGED: assert property (@(posedge clk) disable iff (rst)
        serr_o |-> st_br[BIT_SSE]); // R6

    AST_DPE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pri_data_perr)) |-> st_br[BIT_DPE]); // R2

    AST_RMA_STICKS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pri_mabort)) |-> st_br[BIT_RMA]); // R7

    AST_SBUS_STICKS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((st_sb & $past(sbus_err)) == $past(sbus_err))); // R5

    AST_PRI_RAISES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_serr_en && cfg_pri_perr_en &&
         (pri_data_perr || pri_mst_err))) |-> serr_o); // R3
endmodule

bind bridge_err_agg brerr_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .pri_data_perr  (pri_data_perr),
    .pri_mst_err    (pri_mst_err),
    .pri_mabort     (pri_mabort),
    .sbus_err       (sbus_err),
    .cfg_pri_perr_en(cfg_pri_perr_en),
    .cfg_serr_en    (cfg_serr_en),
    .serr_o         (serr_o),
    .st_br          (br_q),
    .st_sb          (sb_q)
);

// File: tb/bridge_err_agg_test.sv
module bridge_err_agg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pri_data_perr = 0, pri_mst_err = 0, pri_mabort = 0;
    logic        sec_data_perr = 0, sec_mst_err = 0;
    logic [2:0]  sbus_err = 0;
    logic        cfg_pri_perr_en = 0, cfg_sec_perr_en = 0, cfg_serr_en = 0;
    logic [2:0]  cfg_sbus_en = 0;
    logic [1:0]  reg_addr = 0;
    logic        reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        serr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bridge_err_agg uut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic clear_all();
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'hFFFF);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 serr", {15'd0, serr_o}, 16'h0);
        rd(2'd0, d); check("R1 word0", d, 16'h0);
        rd(2'd1, d); check("R1 word1", d, 16'h0);
        rd(2'd2, d); check("R11 addr2", d, 16'h0);
        reg_addr = 2'd0; #1 check("R11 no strobe", reg_rdata, 16'h0);
    endtask

    task automatic t_dpe_no_enable();
        logic [15:0] d;
        cfg_pri_perr_en = 0; cfg_sec_perr_en = 0; cfg_serr_en = 0; cfg_sbus_en = 0;
        pri_data_perr = 1; step(); pri_data_perr = 0;
        check("R2 serr stays low", {15'd0, serr_o}, 16'h0);
        rd(2'd0, d); check("R2 dpe set", d, 16'h0001);
        wr(2'd0, 16'h0001);
        rd(2'd0, d); check("R8 dpe cleared", d, 16'h0000);
    endtask

    task automatic t_primary();
        logic [15:0] d;
        cfg_serr_en = 1; cfg_pri_perr_en = 1;
        pri_mst_err = 1; step(); pri_mst_err = 0;
        check("R3 serr on mst err", {15'd0, serr_o}, 16'h1);
        rd(2'd0, d); check("R6 sse logged", d, 16'h0002);
        step();
        check("R10 serr one cycle", {15'd0, serr_o}, 16'h0);
        cfg_pri_perr_en = 0;
        pri_mst_err = 1; step(); pri_mst_err = 0;
        check("R3 gated off", {15'd0, serr_o}, 16'h0);
        clear_all();
    endtask

    task automatic t_secondary();
        cfg_serr_en = 1; cfg_sec_perr_en = 0;
        sec_data_perr = 1; step(); sec_data_perr = 0;
        check("R4 gated off", {15'd0, serr_o}, 16'h0);
        cfg_sec_perr_en = 1;
        sec_data_perr = 1; step(); sec_data_perr = 0;
        check("R4 data perr", {15'd0, serr_o}, 16'h1);
        sec_mst_err = 1; step(); sec_mst_err = 0;
        check("R4 mst err", {15'd0, serr_o}, 16'h1);
        step();
        check("R10 falls", {15'd0, serr_o}, 16'h0);
        cfg_sec_perr_en = 0;
        clear_all();
    endtask

    task automatic t_sbus();
        logic [15:0] d;
        cfg_serr_en = 1; cfg_sbus_en = 3'b010;
        sbus_err = 3'b101; step(); sbus_err = 0;
        check("R5 disabled sources", {15'd0, serr_o}, 16'h0);
        rd(2'd1, d); check("R5 status regardless", d, 16'h0005);
        sbus_err = 3'b010; step(); sbus_err = 0;
        check("R5 enabled source", {15'd0, serr_o}, 16'h1);
        rd(2'd1, d); check("R5 all set", d, 16'h0007);
        wr(2'd1, 16'h0002);
        rd(2'd1, d); check("R8 sbus partial clear", d, 16'h0005);
        cfg_sbus_en = 0;
        clear_all();
    endtask

    task automatic t_global_gate();
        logic [15:0] d;
        cfg_serr_en = 0; cfg_pri_perr_en = 1;
        pri_data_perr = 1; step(); pri_data_perr = 0;
        check("R6 no serr without global", {15'd0, serr_o}, 16'h0);
        rd(2'd0, d); check("R6 no sse without global", d, 16'h0001);
        cfg_pri_perr_en = 0;
        clear_all();
    endtask

    task automatic t_mabort_w1c();
        logic [15:0] d;
        pri_mabort = 1; step(); pri_mabort = 0;
        rd(2'd0, d); check("R7 rma set", d, 16'h0004);
        pri_data_perr = 1; step(); pri_data_perr = 0;
        wr(2'd0, 16'h0000);
        rd(2'd0, d); check("R8 write zero no effect", d, 16'h0005);
        wr(2'd0, 16'h0004);
        rd(2'd0, d); check("R8 clear rma only", d, 16'h0001);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        reg_addr = 2'd0; reg_wdata = 16'h0001; reg_wr = 1'b1;
        pri_data_perr = 1;
        step();
        reg_wr = 1'b0; reg_wdata = '0; pri_data_perr = 0;
        rd(2'd0, d); check("R9 set beats clear", d, 16'h0001);
        reg_addr = 2'd1; reg_wdata = 16'h0004; reg_wr = 1'b1;
        sbus_err = 3'b100;
        step();
        reg_wr = 1'b0; reg_wdata = '0; sbus_err = 0;
        rd(2'd1, d); check("R9 sbus set beats clear", d, 16'h0004);
        clear_all();
        rd(2'd0, d); check("R8 all cleared", d, 16'h0000);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_dpe_no_enable();
        t_primary();
        t_secondary();
        t_sbus();
        t_global_gate();
        t_mabort_w1c();
        t_set_wins();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule